// File: doc/BRIEF.md
# Metadata Ring Write-Back Engine

This block posts fixed-size metadata entries into a circular ring that lives in host memory. An upstream producer hands over one complete entry at a time on a valid/ready input. The block turns it into a short burst of word writes on a simple write-request interface, at addresses taken from the ring base and the block's own write pointer. Once the last word has been accepted, the block advances its write pointer, wrapping at the end of the ring, and then refreshes a software-visible copy of that pointer one cycle later.

Software sets up the ring through a small CSR write port: two base-address words, the ring size in bytes, and the read pointer. It also clears the write pointer at start-up. The consumer polls a flag bit in each entry, clears it, and returns slots by writing a new read pointer whenever it likes. The engine judges free space against whatever read pointer it holds at that moment. It holds off the producer while the ring is full and while an entry is still being written out.

Top module: `meta_ring_wb`

## Requirements
- R1: After reset the write pointer, the published write pointer and the read pointer are zero, no write request is pending, and `md_ready` is low because the ring size is zero.
- R2: Word k of an entry goes to `{base_hi[15:0], base_lo[31:6], 6'b0} + wptr*ENTRY_BYTES + k*(DATA_W/8)`, where ENTRY_BYTES is ENTRY_WORDS*DATA_W/8 (32 by default). Bits 5:0 of the low base word and bits 31:16 of the high base word are ignored.
- R3: An accepted entry is issued as ENTRY_WORDS requests in order, word k being `md_data[k*DATA_W +: DATA_W]`. A request holds its address and data while `wr_valid` is high and `wr_ready` is low. `wr_last` marks only the final word.
- R4: Bit 0 of the final word, the entry's valid flag, is always driven to 1. Every other bit of every word is passed unchanged.
- R5: The write pointer advances by one on the edge at which the final word is accepted. It becomes 0 instead when the incremented value equals the ring entry count, which is the size in bytes divided by ENTRY_BYTES and rounded down.
- R6: The ring is full when the entry count is zero or when the next write pointer equals the read pointer. While it is full, or while an entry is still being written, `md_ready` is low and no new entry starts.
- R7: `wr_ptr_pub` equals the value `wr_ptr` had one cycle earlier.
- R8: A CSR write to the write-pointer register with data 0 clears the write pointer; any nonzero data is ignored. A clear in the same cycle as an advance wins.
- R9: A CSR write to the read-pointer register loads bits 15:0. The new value governs the full decision from the next cycle.
- R10: CSR select codes are 0 for the low base word, 1 for the high base word, 2 for the ring size in bytes, 3 for the write pointer and 4 for the read pointer. Other codes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 3 | CSR register select |
| csr_wdata | input | 32 | CSR write data |
| md_valid | input | 1 | Metadata entry offered |
| md_ready | output | 1 | Engine accepts an entry |
| md_data | input | ENTRY_WORDS*DATA_W | Entry contents, word 0 in the low bits |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 48 | Byte address of the word |
| wr_data | output | DATA_W | Word to write |
| wr_last | output | 1 | Final word of the entry |
| wr_ptr | output | PTR_W | Internal write pointer |
| wr_ptr_pub | output | PTR_W | Software-visible copy of the write pointer |

## Verification
The hardest case to reach is a write-pointer clear that lands on the very cycle the final word of an entry is accepted. In that cycle the clear and the wrap-or-increment compete for the same register. The stimulus arms a one-shot hook that watches the request port mid-cycle and, when it sees the last word being accepted, raises the clear in that same cycle. Ring wrap under random write back-pressure is also exercised. So are the lazy read-pointer updates that release a full ring, and a shrink of the ring to zero entries.

// File: rtl/mrw_pkg.sv
`timescale 1ns/1ps
package mrw_pkg;
    localparam int HI_W    = 16;
    localparam int LO_W    = 32;
    localparam int ALIGN_W = 6;
    localparam int ADDR_W  = HI_W + LO_W;

    typedef enum logic [2:0] {
        SEL_BASE_LO = 3'd0,
        SEL_BASE_HI = 3'd1,
        SEL_SIZE    = 3'd2,
        SEL_WPTR    = 3'd3,
        SEL_RPTR    = 3'd4
    } csr_sel_e;
endpackage

// File: rtl/mrw_cfg.sv
`timescale 1ns/1ps
module mrw_cfg
    import mrw_pkg::*;
#(
    parameter int PTR_W       = 16,
    parameter int ENTRY_SHIFT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [2:0]        csr_sel,
    input  logic [31:0]       csr_wdata,
    output logic [ADDR_W-1:0] ring_base,
    output logic [PTR_W-1:0]  ring_cnt,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic              wp_clr
);
    typedef struct packed {
        logic [LO_W-ALIGN_W-1:0] lo;
        logic [HI_W-1:0]         hi;
        logic [PTR_W-1:0]        cnt;
        logic [PTR_W-1:0]        rp;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (csr_we) begin
            case (csr_sel)
                SEL_BASE_LO: cfg_d.lo  = csr_wdata[LO_W-1:ALIGN_W];
                SEL_BASE_HI: cfg_d.hi  = csr_wdata[HI_W-1:0];
                SEL_SIZE:    cfg_d.cnt = csr_wdata[ENTRY_SHIFT +: PTR_W];
                SEL_RPTR:    cfg_d.rp  = csr_wdata[PTR_W-1:0];
                default:     cfg_d     = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ring_base = {cfg_q.hi, cfg_q.lo, {ALIGN_W{1'b0}}};
    assign ring_cnt  = cfg_q.cnt;
    assign rd_ptr    = cfg_q.rp;
    assign wp_clr    = csr_we && (csr_sel == SEL_WPTR) && (csr_wdata == 32'd0);

    // R9: a read-pointer write is visible on the next cycle
    p_rptr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we && csr_sel == SEL_RPTR |=> rd_ptr == $past(csr_wdata[PTR_W-1:0]));
    // R10: unknown select codes leave the configuration untouched
    p_bad_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we && csr_sel > 3'd4 |=> $stable(ring_base) && $stable(ring_cnt) && $stable(rd_ptr));
endmodule

// File: rtl/mrw_ptr.sv
`timescale 1ns/1ps
module mrw_ptr #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             clr,
    input  logic [PTR_W-1:0] cnt,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wp,
    output logic [PTR_W-1:0] wp_pub,
    output logic             full
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] pub;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [PTR_W:0]   inc_w;
    logic [PTR_W-1:0] wp_next;

    always_comb begin
        inc_w   = {1'b0, ptr_q.wp} + (PTR_W+1)'(1);
        wp_next = (inc_w == {1'b0, cnt}) ? '0 : inc_w[PTR_W-1:0];
        full    = (cnt == '0) || (wp_next == rd_ptr);

        ptr_d     = ptr_q;
        ptr_d.pub = ptr_q.wp;
        if (clr)      ptr_d.wp = '0;
        else if (adv) ptr_d.wp = wp_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign wp     = ptr_q.wp;
    assign wp_pub = ptr_q.pub;

    // R8: a clear always wins
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> wp == '0);
    // R5: an advance moves by one or wraps to zero
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !clr |=> (wp == '0) || (wp == $past(wp) + PTR_W'(1)));
    // R5: reaching the entry count wraps
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !clr && ({1'b0, wp} + (PTR_W+1)'(1) == {1'b0, cnt}) |=> wp == '0);
    // R7: the published copy trails by one cycle
    p_pub_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> wp_pub == $past(wp));
endmodule

// File: rtl/mrw_beat.sv
`timescale 1ns/1ps
module mrw_beat #(
    parameter int DATA_W = 64,
    parameter int WORDS  = 4,
    parameter int ADDR_W = 48
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [ADDR_W-1:0]       entry_addr,
    input  logic [WORDS*DATA_W-1:0] entry_data,
    input  logic                    wr_ready,
    output logic                    busy,
    output logic                    done,
    output logic                    wr_valid,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [DATA_W-1:0]       wr_data,
    output logic                    wr_last
);
    localparam int BEAT_W     = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int WORD_SHIFT = $clog2(DATA_W / 8);

    typedef struct packed {
        logic                    busy;
        logic [BEAT_W-1:0]       beat;
        logic [ADDR_W-1:0]       addr;
        logic [WORDS*DATA_W-1:0] data;
    } beat_t;

    beat_t st_d, st_q;
    logic [DATA_W-1:0] word;

    always_comb begin
        word     = st_q.data[st_q.beat*DATA_W +: DATA_W];
        wr_last  = st_q.busy && (st_q.beat == BEAT_W'(WORDS - 1));
        wr_valid = st_q.busy;
        wr_addr  = st_q.addr + (ADDR_W'(st_q.beat) << WORD_SHIFT);
        wr_data  = {word[DATA_W-1:1], word[0] | wr_last};
        done     = wr_valid && wr_ready && wr_last;

        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.beat = '0;
                st_d.addr = entry_addr;
                st_d.data = entry_data;
            end
        end else if (wr_ready) begin
            if (wr_last) st_d.busy = 1'b0;
            else         st_d.beat = st_q.beat + BEAT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;

    // R3: a stalled request keeps its address and data
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
    // R4: the final word carries the valid flag
    p_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_last |-> wr_data[0]);
endmodule

// File: rtl/meta_ring_wb.sv
`timescale 1ns/1ps
module meta_ring_wb
    import mrw_pkg::*;
#(
    parameter int DATA_W      = 64,
    parameter int ENTRY_WORDS = 4,
    parameter int PTR_W       = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          csr_we,
    input  logic [2:0]                    csr_sel,
    input  logic [31:0]                   csr_wdata,
    input  logic                          md_valid,
    output logic                          md_ready,
    input  logic [ENTRY_WORDS*DATA_W-1:0] md_data,
    output logic                          wr_valid,
    input  logic                          wr_ready,
    output logic [47:0]                   wr_addr,
    output logic [DATA_W-1:0]             wr_data,
    output logic                          wr_last,
    output logic [PTR_W-1:0]              wr_ptr,
    output logic [PTR_W-1:0]              wr_ptr_pub
);
    localparam int ENTRY_BYTES = ENTRY_WORDS * DATA_W / 8;
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

    logic [ADDR_W-1:0] ring_base;
    logic [ADDR_W-1:0] entry_addr;
    logic [PTR_W-1:0]  ring_cnt, rd_ptr;
    logic              wp_clr, full, busy, done, start;

    mrw_cfg #(.PTR_W(PTR_W), .ENTRY_SHIFT(ENTRY_SHIFT)) u_cfg (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .ring_base(ring_base), .ring_cnt(ring_cnt),
        .rd_ptr(rd_ptr), .wp_clr(wp_clr)
    );

    mrw_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .adv(done), .clr(wp_clr), .cnt(ring_cnt),
        .rd_ptr(rd_ptr), .wp(wr_ptr), .wp_pub(wr_ptr_pub), .full(full)
    );

    assign md_ready   = !busy && !full;
    assign start      = md_valid && md_ready;
    assign entry_addr = ring_base + (ADDR_W'(wr_ptr) << ENTRY_SHIFT);

    mrw_beat #(.DATA_W(DATA_W), .WORDS(ENTRY_WORDS), .ADDR_W(ADDR_W)) u_beat (
        .clk(clk), .rst_n(rst_n), .start(start), .entry_addr(entry_addr),
        .entry_data(md_data), .wr_ready(wr_ready), .busy(busy), .done(done),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_last(wr_last)
    );

    // R6: an idle engine facing a full ring issues nothing next cycle
    p_no_issue_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && full |=> !wr_valid);
    // R6: no acceptance while a previous entry is still in flight
    p_one_inflight_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !md_ready);
endmodule

// File: tb/meta_ring_wb_test.sv
`timescale 1ns/1ps
module meta_ring_wb_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         csr_we = 1'b0;
    logic [2:0]   csr_sel = '0;
    logic [31:0]  csr_wdata = '0;
    logic         md_valid = 1'b0;
    logic         md_ready;
    logic [255:0] md_data = '0;
    logic         wr_valid;
    logic         wr_ready = 1'b0;
    logic [47:0]  wr_addr;
    logic [63:0]  wr_data;
    logic         wr_last;
    logic [15:0]  wr_ptr, wr_ptr_pub;

    meta_ring_wb uut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .md_valid(md_valid), .md_ready(md_ready),
        .md_data(md_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_last(wr_last),
        .wr_ptr(wr_ptr), .wr_ptr_pub(wr_ptr_pub)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    logic [31:0] m_lo = '0, m_hi = '0, m_size = '0;
    int m_rp = 0, m_wp = 0, m_pub = 0;
    logic [47:0] qa[$];
    logic [63:0] qd[$];
    bit          ql[$];
    int  bp_mode = 0;
    bit  arm_clr = 0, clr_hit = 0, fired = 0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_cnt();
        return (m_size >> 5) & 32'hFFFF;
    endfunction

    function automatic int m_next();
        int n = (m_wp + 1) & 32'hFFFF;
        return (n == m_cnt()) ? 0 : n;
    endfunction

    // one clock: inputs set by caller at a negedge
    task automatic step();
        bit exp_ready, adv, clr;
        int old_wp;
        logic [47:0] base;
        wr_ready = (bp_mode == 0) ? 1'b1 : 1'($urandom_range(0, 1));
        #1;
        if (arm_clr && wr_valid && wr_last && wr_ready) begin
            csr_we = 1'b1; csr_sel = 3'd3; csr_wdata = 32'd0;
            arm_clr = 0; clr_hit = 1;
        end
        exp_ready = (qa.size() == 0) && !((m_cnt() == 0) || (m_next() == m_rp));
        chk("R6 R9 md_ready", 64'(md_ready), 64'(exp_ready));
        chk("R3 wr_valid", 64'(wr_valid), 64'(qa.size() != 0));
        if (qa.size() != 0) begin
            chk("R2 R10 wr_addr", 64'(wr_addr), 64'(qa[0]));
            chk("R3 R4 wr_data", wr_data, qd[0]);
            chk("R3 wr_last", 64'(wr_last), 64'(ql[0]));
        end
        chk("R5 R8 wr_ptr", 64'(wr_ptr), 64'(m_wp));
        chk("R7 wr_ptr_pub", 64'(wr_ptr_pub), 64'(m_pub));
        // model next state
        old_wp = m_wp; adv = 0; clr = 0;
        base = {m_hi[15:0], m_lo[31:6], 6'b0};
        fired = md_valid && exp_ready;
        if (qa.size() != 0 && wr_ready) begin
            adv = ql[0];
            void'(qa.pop_front()); void'(qd.pop_front()); void'(ql.pop_front());
        end
        if (fired) begin
            for (int k = 0; k < 4; k++) begin
                logic [63:0] w = md_data[k*64 +: 64];
                if (k == 3) w[0] = 1'b1;
                qa.push_back(base + 48'(old_wp) * 48'd32 + 48'(k * 8));
                qd.push_back(w);
                ql.push_back(k == 3);
            end
        end
        if (csr_we) begin
            case (csr_sel)
                3'd0: m_lo = csr_wdata;
                3'd1: m_hi = csr_wdata & 32'hFFFF;
                3'd2: m_size = csr_wdata;
                3'd3: clr = (csr_wdata == 0);
                3'd4: m_rp = csr_wdata & 32'hFFFF;
                default: ;
            endcase
        end
        if (clr)      m_wp = 0;
        else if (adv) m_wp = m_next();
        m_pub = old_wp;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_write(input logic [2:0] sel, input logic [31:0] data);
        csr_we = 1'b1; csr_sel = sel; csr_wdata = data;
        step();
    endtask

    task automatic send_entry(input int seed);
        for (int k = 0; k < 4; k++)
            md_data[k*64 +: 64] = {32'(seed * 7919 + k), $urandom()} ^ 64'(k);
        md_valid = 1'b1;
        fired = 0;
        for (int n = 0; n < 12 && !fired; n++) step();
        md_valid = 1'b0;
        for (int n = 0; n < 60 && qa.size() != 0; n++) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 md_ready", 64'(md_ready), 64'd0);
        chk("R1 wr_valid", 64'(wr_valid), 64'd0);
        chk("R1 wr_ptr", 64'(wr_ptr), 64'd0);
        chk("R1 wr_ptr_pub", 64'(wr_ptr_pub), 64'd0);
        // R10: configure; unused base bits are dropped (R2)
        csr_write(3'd0, 32'h1234_5678);
        csr_write(3'd1, 32'hFFFF_ABCD);
        csr_write(3'd2, 32'd256);          // 8 entries
        csr_write(3'd4, 32'd0);
        step();
        // R6: fill until full, no back-pressure
        bp_mode = 0;
        for (int e = 0; e < 9; e++) send_entry(e);
        chk("R6 ring full after 7", 64'(wr_ptr), 64'd7);
        // R9: returning slots releases the ring; R5 wrap under back-pressure
        csr_write(3'd4, 32'd5);
        bp_mode = 1;
        for (int e = 0; e < 7; e++) send_entry(100 + e);
        chk("R5 wrapped pointer", 64'(wr_ptr), 64'd4);
        // R8: nonzero write to the pointer register ignored; R10 bad select
        csr_write(3'd3, 32'd5);
        csr_write(3'd6, 32'h0000_0000);
        csr_write(3'd7, 32'hFFFF_FFFF);
        step();
        chk("R8 nonzero ignored", 64'(wr_ptr), 64'd4);
        // R8: clear collides with final-word acceptance
        csr_write(3'd4, 32'd1);
        bp_mode = 0;
        arm_clr = 1;
        send_entry(200);
        step();
        chk("R8 clear hit last beat", 64'(clr_hit), 64'd1);
        chk("R8 clear wins", 64'(wr_ptr), 64'd0);
        // new base and a 3-entry ring with a non-multiple size
        csr_write(3'd0, 32'h0000_1FC0);
        csr_write(3'd1, 32'h0000_0002);
        csr_write(3'd2, 32'd100);
        csr_write(3'd4, 32'd0);
        bp_mode = 1;
        for (int e = 0; e < 3; e++) send_entry(300 + e);
        chk("R6 small ring full", 64'(md_ready), 64'd0);
        csr_write(3'd4, 32'd2);
        for (int e = 0; e < 2; e++) send_entry(400 + e);
        // R6: zero-size ring is full
        csr_write(3'd3, 32'd0);
        csr_write(3'd2, 32'd0);
        send_entry(500);
        for (int n = 0; n < 5; n++) step();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule